// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block gathers eight single-cycle event pulses from a serial flash controller and turns them into interrupt state for software. Each pulse sets a sticky bit in a raw status register. That bit stays set until software clears it, whatever the mask holds. A mask register, in which a one silences its source, gates the raw bits into a masked status view. The OR of the masked view drives one interrupt line.

Software reaches the unit through a small register port with four word addresses. It can write the mask, write ones to a clear register, and read back the mask, the raw view and the masked view. Read data is combinational from the read address. Writes take effect at the next rising clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the mask reads 0xFF, the raw status reads 0x00 and `irq_o` is low.
- R2: A one on `evt_i[i]` at a rising edge sets raw bit i at that edge. The bit holds until a clear write removes it. The bit order is 0 receive full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer finished, 5 bus error, 6 protocol error, 7 DMA done.
- R3: The raw status view (address 2) shows latched events even when every mask bit is 1.
- R4: The masked status view (address 3) equals raw AND NOT mask.
- R5: `irq_o` is high exactly when at least one masked status bit is 1.
- R6: A write to the clear register (address 1) clears each raw bit whose data bit is 1. Bits written 0 keep their value.
- R7: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: A write to address 0 loads the mask, and address 0 reads it back. A mask bit of 1 blocks its source and 0 enables it. The mask changes only on such a write.
- R9: Reading the clear register (address 1) returns 0x00.
- R10: Writes to address 2 or address 3 change neither the raw status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event pulses, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 mask, 1 clear, 2 raw, 3 masked |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address, same map as the write address |
| rd_data_o | output | 8 | Read data for `rd_addr_i` |
| irq_o | output | 1 | Interrupt, OR of the masked status |

## Verification
The bench drives an event and a clear on the same bit in the same cycle. A design that gave the clear priority would drop that event, and the raw view would read zero for the bit. It latches events while they are fully masked and then reads the raw view. A design that gated the latch input with the mask would lose those events. It also unmasks a source that is already pending and expects `irq_o` to rise. It writes clear data with zero bits, writes to the read-only addresses, and pulses each source alone. These catch an inverted clear sense, stray decode of the status addresses, and a swapped bit order.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASK   = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_RAW    = 2'd2,
        REG_MASKED = 2'd3
    } isu_reg_e;

    // source positions; software decodes these, so the order is fixed
    localparam int EV_RX_FULL   = 0;
    localparam int EV_RX_UNDER  = 1;
    localparam int EV_TX_OVER   = 2;
    localparam int EV_TX_EMPTY  = 3;
    localparam int EV_XFER_DONE = 4;
    localparam int EV_BUS_ERR   = 5;
    localparam int EV_PROTO_ERR = 6;
    localparam int EV_DMA_DONE  = 7;
endpackage

// File: rtl/isu_raw_latch.sv
module isu_raw_latch #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               clr_en_i,
    input  logic [NUM_EVT-1:0] clr_bits_i,
    output logic [NUM_EVT-1:0] raw_o
);
    typedef struct packed {
        logic [NUM_EVT-1:0] raw;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_EVT-1:0] bit_nxt;

    // per source: a new event beats a clear in the same cycle (R7)
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        assign bit_nxt[i] = evt_i[i] | (st_q.raw[i] & ~(clr_en_i & clr_bits_i[i]));
    end

    always_comb begin
        st_d     = st_q;
        st_d.raw = bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_i,
    input  logic [NUM_EVT-1:0] ld_val_i,
    output logic [NUM_EVT-1:0] mask_o
);
    typedef struct packed {
        logic [NUM_EVT-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) st_d.mask = ld_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mask <= '1;
        else        st_q      <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/isu_gate.sv
module isu_gate #(
    parameter int NUM_EVT = 8
) (
    input  logic [NUM_EVT-1:0] raw_i,
    input  logic [NUM_EVT-1:0] mask_i,
    output logic [NUM_EVT-1:0] masked_o,
    output logic               irq_o
);
    always_comb begin
        masked_o = raw_i & ~mask_i;
        irq_o    = |masked_o;
    end
endmodule

// File: rtl/isu_read_mux.sv
module isu_read_mux #(
    parameter int NUM_EVT = 8
) (
    input  logic [isu_pkg::ADDR_W-1:0] addr_i,
    input  logic [NUM_EVT-1:0]         mask_i,
    input  logic [NUM_EVT-1:0]         raw_i,
    input  logic [NUM_EVT-1:0]         masked_i,
    output logic [NUM_EVT-1:0]         data_o
);
    import isu_pkg::*;

    always_comb begin
        unique case (isu_reg_e'(addr_i))
            REG_MASK:   data_o = mask_i;
            REG_CLEAR:  data_o = '0;
            REG_RAW:    data_o = raw_i;
            REG_MASKED: data_o = masked_i;
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int NUM_EVT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_EVT-1:0]         evt_i,
    input  logic                       wr_en_i,
    input  logic [isu_pkg::ADDR_W-1:0] wr_addr_i,
    input  logic [NUM_EVT-1:0]         wr_data_i,
    input  logic [isu_pkg::ADDR_W-1:0] rd_addr_i,
    output logic [NUM_EVT-1:0]         rd_data_o,
    output logic                       irq_o
);
    import isu_pkg::*;

    logic               clr_hit;
    logic               mask_hit;
    logic [NUM_EVT-1:0] raw_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] masked;

    assign clr_hit  = wr_en_i && (wr_addr_i == REG_CLEAR);
    assign mask_hit = wr_en_i && (wr_addr_i == REG_MASK);

    isu_raw_latch #(.NUM_EVT(NUM_EVT)) u_raw (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_en_i   (clr_hit),
        .clr_bits_i (wr_data_i),
        .raw_o      (raw_q)
    );

    isu_mask_reg #(.NUM_EVT(NUM_EVT)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (mask_hit),
        .ld_val_i (wr_data_i),
        .mask_o   (mask_q)
    );

    isu_gate #(.NUM_EVT(NUM_EVT)) u_gate (
        .raw_i    (raw_q),
        .mask_i   (mask_q),
        .masked_o (masked),
        .irq_o    (irq_o)
    );

    isu_read_mux #(.NUM_EVT(NUM_EVT)) u_rd (
        .addr_i   (rd_addr_i),
        .mask_i   (mask_q),
        .raw_i    (raw_q),
        .masked_i (masked),
        .data_o   (rd_data_o)
    );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
    parameter int NUM_EVT = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_EVT-1:0]         evt_i,
    input logic                       wr_en_i,
    input logic [isu_pkg::ADDR_W-1:0] wr_addr_i,
    input logic [NUM_EVT-1:0]         wr_data_i,
    input logic [isu_pkg::ADDR_W-1:0] rd_addr_i,
    input logic [NUM_EVT-1:0]         rd_data_o,
    input logic                       irq_o,
    input logic [NUM_EVT-1:0]         raw_q,
    input logic [NUM_EVT-1:0]         mask_q
);
    import isu_pkg::*;

    logic clr_wr, mask_wr;
    assign clr_wr  = wr_en_i && (wr_addr_i == REG_CLEAR);
    assign mask_wr = wr_en_i && (wr_addr_i == REG_MASK);

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

    assert_raw_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i == '0) && !clr_wr) |=> $stable(raw_q));

    assert_clear_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((raw_q & $past(wr_data_i & ~evt_i)) == '0));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((evt_i & wr_data_i) != '0))
        |=> ((raw_q & $past(evt_i & wr_data_i)) == $past(evt_i & wr_data_i)));

    assert_irq_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((raw_q & ~mask_q) != '0));

    assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(wr_data_i)));

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));

    assert_masked_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == REG_MASKED) |-> (rd_data_o == (raw_q & ~mask_q)));

    assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == REG_CLEAR) |-> (rd_data_o == '0));
endmodule

bind irq_status_unit irq_status_unit_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .raw_q     (raw_q),
    .mask_q    (mask_q)
);

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
    localparam int NE = 8;

    typedef struct {
        logic [1:0]    addr;
        logic [NE-1:0] data;
        logic          irq;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_i = '0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    wr_addr_i = '0;
    logic [NE-1:0] wr_data_i = '0;
    logic [1:0]    rd_addr_i = '0;
    logic [NE-1:0] rd_data_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    logic [NE-1:0] m_raw;
    logic [NE-1:0] m_mask;

    always #4 clk = ~clk;

    irq_status_unit #(.NUM_EVT(NE)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (rd_data_o !== e.data || irq_o !== e.irq) begin
                errors++;
                $display("FAIL %s addr=%0d data act=%02h exp=%02h irq act=%0b exp=%0b",
                         e.req, e.addr, rd_data_o, e.data, irq_o, e.irq);
            end
        end
    end

    function automatic logic [NE-1:0] view(input logic [1:0] a);
        case (a)
            2'd0: view = m_mask;
            2'd1: view = '0;
            2'd2: view = m_raw;
            default: view = m_raw & ~m_mask;
        endcase
    endfunction

    task automatic expect_rd(input logic [1:0] a, input string req);
        exp_t e;
        @(posedge clk); #1;
        rd_addr_i = a;
        e.addr = a;
        e.data = view(a);
        e.irq  = |(m_raw & ~m_mask);
        e.req  = req;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // one cycle of stimulus; model updated per the requirements
    task automatic cycle(input logic [NE-1:0] ev, input logic we,
                         input logic [1:0] a, input logic [NE-1:0] d);
        @(posedge clk); #1;
        evt_i = ev; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
        @(posedge clk); #1;
        evt_i = '0; wr_en_i = 1'b0;
        if (we && a == 2'd1) m_raw = m_raw & ~d;
        if (we && a == 2'd0) m_mask = d;
        m_raw = m_raw | ev;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_raw = '0; m_mask = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_rd(2'd0, "R1 mask reset");
        expect_rd(2'd2, "R1 raw reset");
        expect_rd(2'd3, "R1 masked reset");

        cycle(8'h05, 1'b0, 2'd0, 8'h00);
        expect_rd(2'd2, "R3 raw while masked");
        expect_rd(2'd3, "R4 masked all blocked");

        cycle(8'h00, 1'b1, 2'd0, 8'hFE);
        expect_rd(2'd0, "R8 mask readback");
        expect_rd(2'd3, "R5 pending source unmasked");

        cycle(8'h80, 1'b0, 2'd0, 8'h00);
        repeat (4) @(posedge clk);
        expect_rd(2'd2, "R2 sticky raw");

        cycle(8'h00, 1'b1, 2'd1, 8'h00);
        expect_rd(2'd2, "R6 zero clear no effect");
        cycle(8'h00, 1'b1, 2'd1, 8'h04);
        expect_rd(2'd2, "R6 single bit clear");

        cycle(8'h01, 1'b1, 2'd1, 8'h01);
        expect_rd(2'd2, "R7 event beats clear");

        cycle(8'h00, 1'b1, 2'd1, 8'h01);
        expect_rd(2'd3, "R5 irq low after clear");
        cycle(8'h00, 1'b1, 2'd0, 8'h7F);
        expect_rd(2'd3, "R4 masked with new mask");

        cycle(8'h00, 1'b1, 2'd2, 8'hFF);
        expect_rd(2'd2, "R10 raw write ignored");
        cycle(8'h00, 1'b1, 2'd3, 8'h00);
        expect_rd(2'd0, "R10 mask untouched");
        expect_rd(2'd3, "R10 masked view unchanged");
        expect_rd(2'd1, "R9 clear reads zero");

        for (int i = 0; i < NE; i++) begin
            cycle(8'h00, 1'b1, 2'd1, 8'hFF);
            cycle(NE'(1) << i, 1'b0, 2'd0, 8'h00);
            expect_rd(2'd2, "R2 per source bit order");
        end

        cycle(8'h00, 1'b1, 2'd0, 8'h00);
        cycle(8'h5A, 1'b1, 2'd1, 8'hFF);
        expect_rd(2'd3, "R7 multi bit event beats clear");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule